// File: doc/BRIEF.md
# Byte-wide host register interface

This block sits between an 8-bit microprocessor-style bus and a serial avionics word controller. The host sees a small register file behind a 3-bit address, an active-low chip select and separate active-low read and write strobes. A 32-bit serial word crosses the 8-bit bus as four byte transfers. An internal byte pointer selects which quarter of the word each access carries. The pointer wraps after the fourth access and restarts whenever the host drops chip select or moves to another address.

On the write side the block assembles transmit words and hands each complete word to an external FIFO as a one-cycle push. It also holds the configuration byte and the two receiver label bytes, and it issues the receiver resets and the master reset. On the read side it returns bytes of the two receive holding registers, a byte of interrupt flags and a byte of transmitter and configuration status. The strobes pass through a synchroniser, and an access takes effect on the rising (trailing) edge of the strobe. The serialiser, the receivers and the FIFO storage live outside this block.

Top module: `host_byte_bridge`

## Requirements
- R1: A read with address 000 returns the interrupt byte, 001 a byte of receiver 1's word, 010 a byte of receiver 2's word, 011 the general status byte, and any address with bit 2 set returns 00h. `bus_rdata` is 00h whenever no read is in progress.
- R2: Word bit k (ARINC bit k+1) is `word[k]`. Access n (n = 0..3) of a word carries `word[8n+7:8n]`, with the lowest-numbered bit on data bit 0. The fifth consecutive read of the same receiver returns byte 0 again.
- R3: The byte pointer returns to 0 when chip select goes high, and when an access uses a different address from the previous access of the same direction.
- R4: Four consecutive writes to address 000 build a word from bytes 0..3. After the fourth write `tx_push` is high for exactly one cycle, and `tx_word` carries the assembled word.
- R5: If `tx_fifo_full` is high when the fourth byte is taken, no push occurs and the word is dropped.
- R6: A write to 011 loads the configuration byte. Bit 2 drives `cfg_parity_odd`, bits 5:3 drive `cfg_rate` (receiver 1, receiver 2, transmitter from bit 0 up), and bits 7:6 drive `cfg_clk_sel`. The general status byte is {config[7:2], `tx_bit_clk`, `tx_line_data`}. The configuration changes only through such a write.
- R7: The interrupt byte is {`tx_fifo_full`, `tx_empty`, `rx2_flags`[2:0], `rx1_flags`[2:0]}. In each flag triple, bit 0 is word received, bit 1 is parity error and bit 2 is premature idle.
- R8: A write to 001 or 010 loads that receiver's label and raises its `rx_rst` bit for one cycle. Configuration bits 0 and 1 hold `rx_rst`[0] and `rx_rst`[1] high while they are set.
- R9: A write to any address with bit 2 set raises `master_reset` and both `rx_rst` bits for one cycle, whatever the data. It clears the byte pointers and leaves the configuration and labels unchanged.
- R10: While `rst_n` is low, `master_reset` is high and the configuration, labels and pointers are cleared.
- R11: Nothing changes while a write strobe is held low. The write takes effect only after the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Hardware reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 00h when idle |
| tx_word | output | 32 | Last assembled transmit word |
| tx_push | output | 1 | One-cycle push of `tx_word` into the FIFO |
| tx_fifo_full | input | 1 | Transmit FIFO has no room |
| tx_empty | input | 1 | FIFO and serialiser empty |
| tx_line_data | input | 1 | Live transmit data bit |
| tx_bit_clk | input | 1 | Transmit bit clock |
| rx1_word | input | 32 | Receiver 1 holding register |
| rx2_word | input | 32 | Receiver 2 holding register |
| rx1_flags | input | 3 | Receiver 1 flags: received, parity error, premature idle |
| rx2_flags | input | 3 | Receiver 2 flags, same order |
| rx1_label | output | 8 | Receiver 1 label byte |
| rx2_label | output | 8 | Receiver 2 label byte |
| rx_rst | output | 2 | Receiver resets, bit 0 for receiver 1 |
| master_reset | output | 1 | Master reset to the controller |
| cfg_parity_odd | output | 1 | Parity sense, 1 = odd |
| cfg_rate | output | 3 | Rate selects, 1 = high speed |
| cfg_clk_sel | output | 2 | Input clock select |

## Verification
The assertions check four properties on every cycle: a push never follows a full FIFO, push and master reset last one cycle, master reset drives both receiver resets, and the read bus returns to zero when no read is in progress. They also check that the configuration outputs move only in the cycle after a synchronised write edge to address 011. The directed scenarios cover what a single-cycle property cannot: the byte order within a word, the pointer wrap and restart, the exact bytes of the two status registers, dropped words when the FIFO is full, the count of reset pulses, and the absence of any effect while a strobe is still low.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
    parameter int unsigned BYTE_W     = 8;
    parameter int unsigned WORD_BYTES = 4;
    parameter int unsigned ADDR_W     = 3;
    localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES;
    localparam int unsigned PTR_W     = $clog2(WORD_BYTES);
    localparam int unsigned BUF_W     = WORD_W - BYTE_W;

    // low address bits when address bit 2 is clear
    localparam logic [1:0] SEL_PRIMARY = 2'd0;  // read: interrupt byte, write: transmit data
    localparam logic [1:0] SEL_RX1     = 2'd1;
    localparam logic [1:0] SEL_RX2     = 2'd2;
    localparam logic [1:0] SEL_CFG     = 2'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] lbl1;
        logic [BYTE_W-1:0] lbl2;
        logic [BUF_W-1:0]  tx_buf;
        logic [WORD_W-1:0] tx_word;
        logic              tx_push;
        logic              mrst;
        logic [1:0]        lbl_pulse;
        logic [1:0]        strb_prev;   // [1] read, [0] write
        logic [BYTE_W-1:0] rdata;
    } hbb_state_t;
endpackage

// File: rtl/hbb_sync_edge.sv
module hbb_sync_edge #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {(STAGES*W){RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/hbb_byte_ptr.sv
module hbb_byte_ptr
    import hbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  ptr
);
    typedef struct packed {
        logic [PTR_W-1:0]  idx;
        logic [ADDR_W-1:0] last;
        logic              valid;
    } ptr_state_t;

    ptr_state_t p_d, p_q;
    logic       same_addr;

    always_comb begin
        same_addr = p_q.valid && (addr == p_q.last);
        ptr       = same_addr ? p_q.idx : '0;
        p_d       = p_q;
        if (clr) begin
            p_d.idx   = '0;
            p_d.valid = 1'b0;
        end else if (step) begin
            p_d.idx   = PTR_W'(ptr + 1'b1);
            p_d.last  = addr;
            p_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/hbb_read_mux.sv
module hbb_read_mux
    import hbb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [WORD_W-1:0] rx1_word,
    input  logic [WORD_W-1:0] rx2_word,
    input  logic [BYTE_W-1:0] irq_byte,
    input  logic [BYTE_W-1:0] gen_byte,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] rx1_sel, rx2_sel;

    always_comb begin
        rx1_sel = '0;
        rx2_sel = '0;
        for (int b = 0; b < int'(WORD_BYTES); b++) begin
            if (ptr == PTR_W'(b)) begin
                rx1_sel = rx1_word[b*BYTE_W +: BYTE_W];
                rx2_sel = rx2_word[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        byte_o = '0;
        if (!addr[ADDR_W-1]) begin
            unique case (addr[1:0])
                SEL_PRIMARY: byte_o = irq_byte;
                SEL_RX1:     byte_o = rx1_sel;
                SEL_RX2:     byte_o = rx2_sel;
                SEL_CFG:     byte_o = gen_byte;
                default:     byte_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/host_byte_bridge.sv
module host_byte_bridge
    import hbb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cs_n,
    input  logic                bus_rd_n,
    input  logic                bus_wr_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic [WORD_W-1:0]   tx_word,
    output logic                tx_push,
    input  logic                tx_fifo_full,
    input  logic                tx_empty,
    input  logic                tx_line_data,
    input  logic                tx_bit_clk,
    input  logic [WORD_W-1:0]   rx1_word,
    input  logic [WORD_W-1:0]   rx2_word,
    input  logic [2:0]          rx1_flags,
    input  logic [2:0]          rx2_flags,
    output logic [BYTE_W-1:0]   rx1_label,
    output logic [BYTE_W-1:0]   rx2_label,
    output logic [1:0]          rx_rst,
    output logic                master_reset,
    output logic                cfg_parity_odd,
    output logic [2:0]          cfg_rate,
    output logic [1:0]          cfg_clk_sel
);
    localparam int unsigned DAT_W = ADDR_W + BYTE_W;

    hbb_state_t s_d, s_q;

    logic [2:0]        ctl_s;
    logic [DAT_W-1:0]  dat_s;
    logic              cs_s, rd_s, wr_s;
    logic [ADDR_W-1:0] addr_s;
    logic [BYTE_W-1:0] wdata_s;
    logic              rd_rise, wr_rise, ptr_clr;
    logic [PTR_W-1:0]  rptr, wptr;
    logic [BYTE_W-1:0] irq_byte, gen_byte, rd_byte;

    // strobes and the address/data they qualify share one pipeline depth
    hbb_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({bus_cs_n, bus_rd_n, bus_wr_n}), .q(ctl_s)
    );
    hbb_sync_edge #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_wdata}), .q(dat_s)
    );

    assign cs_s    = ctl_s[2];
    assign rd_s    = ctl_s[1];
    assign wr_s    = ctl_s[0];
    assign addr_s  = dat_s[DAT_W-1:BYTE_W];
    assign wdata_s = dat_s[BYTE_W-1:0];

    assign rd_rise = !cs_s && rd_s && !s_q.strb_prev[1];
    assign wr_rise = !cs_s && wr_s && !s_q.strb_prev[0];
    assign ptr_clr = cs_s || s_q.mrst;

    hbb_byte_ptr u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .step(rd_rise),
        .addr(addr_s), .ptr(rptr)
    );
    hbb_byte_ptr u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .step(wr_rise),
        .addr(addr_s), .ptr(wptr)
    );

    assign irq_byte = {tx_fifo_full, tx_empty, rx2_flags, rx1_flags};
    assign gen_byte = {s_q.cfg[7:2], tx_bit_clk, tx_line_data};

    hbb_read_mux u_rmux (
        .addr(addr_s), .ptr(rptr), .rx1_word(rx1_word), .rx2_word(rx2_word),
        .irq_byte(irq_byte), .gen_byte(gen_byte), .byte_o(rd_byte)
    );

    always_comb begin
        s_d           = s_q;
        s_d.tx_push   = 1'b0;
        s_d.mrst      = 1'b0;
        s_d.lbl_pulse = 2'b00;
        s_d.strb_prev = {rd_s, wr_s};
        s_d.rdata     = (!cs_s && !rd_s) ? rd_byte : '0;

        if (wr_rise) begin
            if (addr_s[ADDR_W-1]) begin
                s_d.mrst = 1'b1;
            end else begin
                unique case (addr_s[1:0])
                    SEL_PRIMARY: begin
                        if (wptr == PTR_W'(WORD_BYTES - 1)) begin
                            if (!tx_fifo_full) begin
                                s_d.tx_word = {wdata_s, s_q.tx_buf};
                                s_d.tx_push = 1'b1;
                            end
                        end else begin
                            for (int b = 0; b < int'(WORD_BYTES) - 1; b++) begin
                                if (wptr == PTR_W'(b)) s_d.tx_buf[b*BYTE_W +: BYTE_W] = wdata_s;
                            end
                        end
                    end
                    SEL_RX1: begin
                        s_d.lbl1         = wdata_s;
                        s_d.lbl_pulse[0] = 1'b1;
                    end
                    SEL_RX2: begin
                        s_d.lbl2         = wdata_s;
                        s_d.lbl_pulse[1] = 1'b1;
                    end
                    SEL_CFG: s_d.cfg = wdata_s;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.mrst      <= 1'b1;
            s_q.strb_prev <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata      = s_q.rdata;
    assign tx_word        = s_q.tx_word;
    assign tx_push        = s_q.tx_push;
    assign rx1_label      = s_q.lbl1;
    assign rx2_label      = s_q.lbl2;
    assign master_reset   = s_q.mrst;
    assign rx_rst         = s_q.cfg[1:0] | s_q.lbl_pulse | {2{s_q.mrst}};
    assign cfg_parity_odd = s_q.cfg[2];
    assign cfg_rate       = s_q.cfg[5:3];
    assign cfg_clk_sel    = s_q.cfg[7:6];
endmodule

// File: rtl/hbb_checker.sv
module hbb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_push,
    input logic       tx_fifo_full,
    input logic       master_reset,
    input logic [1:0] rx_rst,
    input logic       cfg_parity_odd,
    input logic [2:0] cfg_rate,
    input logic [1:0] cfg_clk_sel,
    input logic       wr_rise,
    input logic       cs_s,
    input logic       rd_s,
    input logic [2:0] addr_s,
    input logic [7:0] bus_rdata
);
    // R5
    push_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !$past(tx_fifo_full));

    // R4
    push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !tx_push);

    // R9
    mrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_reset |=> !master_reset);

    // R9
    mrst_rx_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_reset |-> (rx_rst == 2'b11));

    // R6
    cfg_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_clk_sel, cfg_rate, cfg_parity_odd})
            |-> $past(wr_rise && !cs_s && (addr_s == 3'b011)));

    // R1
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s || cs_s) |=> (bus_rdata == 8'h00));
endmodule

bind host_byte_bridge hbb_checker u_hbb_checker (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_fifo_full(tx_fifo_full),
    .master_reset(master_reset), .rx_rst(rx_rst), .cfg_parity_odd(cfg_parity_odd),
    .cfg_rate(cfg_rate), .cfg_clk_sel(cfg_clk_sel), .wr_rise(wr_rise),
    .cs_s(cs_s), .rd_s(rd_s), .addr_s(addr_s), .bus_rdata(bus_rdata)
);

// File: tb/host_byte_bridge_bench.sv
module host_byte_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] tx_word;
    logic        tx_push;
    logic        tx_fifo_full = 1'b0, tx_empty = 1'b1;
    logic        tx_line_data = 1'b0, tx_bit_clk = 1'b0;
    logic [31:0] rx1_word = 32'hA1B2C3D4, rx2_word = 32'h5566_7788;
    logic [2:0]  rx1_flags = '0, rx2_flags = '0;
    logic [7:0]  rx1_label, rx2_label;
    logic [1:0]  rx_rst;
    logic        master_reset, cfg_parity_odd;
    logic [2:0]  cfg_rate;
    logic [1:0]  cfg_clk_sel;

    int total = 0, bad = 0;
    int push_cnt = 0, mrst_cnt = 0, rr0_cnt = 0, rr1_cnt = 0;
    logic [31:0] last_push = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    host_byte_bridge u_host_byte_bridge (.*);

    always @(negedge clk) begin
        if (tx_push) begin push_cnt++; last_push = tx_word; end
        if (master_reset) mrst_cnt++;
        if (rx_rst[0]) rr0_cnt++;
        if (rx_rst[1]) rr1_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();  bus_cs_n = 1'b0; idle(4); endtask
    task automatic cs_off(); bus_cs_n = 1'b1; idle(6); endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; idle(3);
        bus_wr_n = 1'b0; idle(6);
        bus_wr_n = 1'b1; idle(6);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; idle(3);
        bus_rd_n = 1'b0; idle(6);
        d = bus_rdata;
        bus_rd_n = 1'b1; idle(6);
    endtask

    task automatic t_reset();
        idle(3);
        check("R10 master_reset held in reset", {31'd0, master_reset}, 32'd1);
        rst_n = 1'b1; idle(4);
        check("R10 cfg after reset", {26'd0, cfg_clk_sel, cfg_rate, cfg_parity_odd}, 32'd0);
        check("R10 labels after reset", {16'd0, rx1_label, rx2_label}, 32'd0);
        check("R10 master_reset released", {30'd0, rx_rst, master_reset}, 32'd0);
        check("R1 idle rdata", {24'd0, bus_rdata}, 32'd0);
    endtask

    task automatic t_rx_read();
        logic [7:0] d;
        cs_on();
        for (int n = 0; n < 4; n++) begin
            rd(3'b001, d);
            check("R2 rx1 byte order", {24'd0, d}, {24'd0, rx1_word[8*n +: 8]});
        end
        rd(3'b001, d);
        check("R2 fifth read wraps", {24'd0, d}, 32'h0000_00D4);
        rd(3'b010, d);
        rd(3'b010, d);
        check("R1 rx2 byte 1", {24'd0, d}, 32'h0000_0077);
        cs_off();
    endtask

    task automatic t_restart();
        logic [7:0] d;
        cs_on();
        rd(3'b001, d);
        rd(3'b010, d);
        rd(3'b001, d);
        check("R3 address change restarts", {24'd0, d}, 32'h0000_00D4);
        cs_off();
        cs_on();
        rd(3'b001, d);
        check("R3 chip select restarts", {24'd0, d}, 32'h0000_00D4);
        cs_off();
    endtask

    task automatic t_status();
        logic [7:0] d;
        rx1_flags = 3'b101; rx2_flags = 3'b010; tx_fifo_full = 1'b1; tx_empty = 1'b0;
        cs_on();
        rd(3'b000, d);
        check("R7 interrupt byte", {24'd0, d}, 32'h0000_0095);
        rx1_flags = 3'b000; rx2_flags = 3'b100; tx_fifo_full = 1'b0; tx_empty = 1'b1;
        rd(3'b000, d);
        check("R7 interrupt byte 2", {24'd0, d}, 32'h0000_0060);
        rd(3'b100, d);
        check("R1 address 100 zero", {24'd0, d}, 32'd0);
        rd(3'b111, d);
        check("R1 address 111 zero", {24'd0, d}, 32'd0);
        cs_off();
    endtask

    task automatic t_cfg();
        logic [7:0] d;
        cs_on();
        wr(3'b011, 8'hB4);
        check("R6 cfg fields", {26'd0, cfg_clk_sel, cfg_rate, cfg_parity_odd}, {26'd0, 2'b10, 3'b110, 1'b1});
        check("R8 cfg rx resets clear", {30'd0, rx_rst}, 32'd0);
        tx_line_data = 1'b1; tx_bit_clk = 1'b0;
        rd(3'b011, d);
        check("R6 general status", {24'd0, d}, 32'h0000_00B5);
        tx_line_data = 1'b0; tx_bit_clk = 1'b1;
        rd(3'b011, d);
        check("R6 general status live bits", {24'd0, d}, 32'h0000_00B6);
        wr(3'b011, 8'hB7);
        check("R8 cfg holds rx resets", {30'd0, rx_rst}, 32'd3);
        wr(3'b011, 8'hB4);
        cs_off();
    endtask

    task automatic t_strobe_edge();
        cs_on();
        bus_addr = 3'b011; bus_wdata = 8'h08; idle(3);
        bus_wr_n = 1'b0; idle(8);
        check("R11 no effect while strobe low", {29'd0, cfg_rate}, 32'd6);
        bus_wr_n = 1'b1; idle(6);
        check("R11 effect after rising edge", {29'd0, cfg_rate}, 32'd1);
        wr(3'b011, 8'hB4);
        cs_off();
    endtask

    task automatic t_tx();
        int p0;
        p0 = push_cnt;
        cs_on();
        wr(3'b000, 8'h11); wr(3'b000, 8'h22); wr(3'b000, 8'h33); wr(3'b000, 8'h44);
        check("R4 one push", push_cnt - p0, 32'd1);
        check("R4 pushed word", last_push, 32'h4433_2211);
        cs_off();
        cs_on();
        wr(3'b000, 8'hAA); wr(3'b000, 8'hBB);
        cs_off();
        cs_on();
        wr(3'b000, 8'h01); wr(3'b000, 8'h02); wr(3'b000, 8'h03); wr(3'b000, 8'h04);
        check("R3 partial word discarded", last_push, 32'h0403_0201);
        cs_off();
        p0 = push_cnt;
        tx_fifo_full = 1'b1;
        cs_on();
        wr(3'b000, 8'h99); wr(3'b000, 8'h98); wr(3'b000, 8'h97); wr(3'b000, 8'h96);
        cs_off();
        tx_fifo_full = 1'b0;
        check("R5 no push when full", push_cnt - p0, 32'd0);
        check("R5 tx_word unchanged", tx_word, 32'h0403_0201);
    endtask

    task automatic t_label();
        rr0_cnt = 0; rr1_cnt = 0;
        cs_on();
        wr(3'b001, 8'h5A);
        cs_off();
        check("R8 rx1 label", {24'd0, rx1_label}, 32'h0000_005A);
        check("R8 rx1 reset pulse", rr0_cnt, 32'd1);
        check("R8 rx2 untouched", rr1_cnt, 32'd0);
        rr0_cnt = 0;
        cs_on();
        wr(3'b010, 8'h00);
        cs_off();
        check("R8 rx2 reset pulse", {rr0_cnt[15:0], rr1_cnt[15:0]}, 32'h0000_0001);
    endtask

    task automatic t_master();
        logic [7:0] d;
        mrst_cnt = 0; rr0_cnt = 0; rr1_cnt = 0;
        cs_on();
        rd(3'b001, d);
        wr(3'b110, 8'h00);
        rd(3'b001, d);
        check("R9 pointer cleared", {24'd0, d}, 32'h0000_00D4);
        cs_off();
        check("R9 single master pulse", mrst_cnt, 32'd1);
        check("R9 both rx resets", {rr0_cnt[15:0], rr1_cnt[15:0]}, 32'h0001_0001);
        check("R9 cfg kept", {26'd0, cfg_clk_sel, cfg_rate, cfg_parity_odd}, {26'd0, 2'b10, 3'b110, 1'b1});
        check("R9 label kept", {24'd0, rx1_label}, 32'h0000_005A);
    endtask

    task automatic t_hw_reset();
        rst_n = 1'b0; idle(2);
        check("R10 master_reset during reset", {31'd0, master_reset}, 32'd1);
        rst_n = 1'b1; idle(4);
        check("R10 cfg cleared", {26'd0, cfg_clk_sel, cfg_rate, cfg_parity_odd}, 32'd0);
        check("R10 label cleared", {24'd0, rx1_label}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_rx_read();
        t_restart();
        t_status();
        t_cfg();
        t_strobe_edge();
        t_tx();
        t_label();
        t_master();
        t_hw_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule